// File: doc/BRIEF.md
# Inbound DMA Address Translator

This block sits on the inbound path of a host bridge and turns the 64-bit address a device drives on its bus into the system address the memory fabric should see. Each request is classified into one of five windows: a 64-bit direct window, a 32-bit direct window based on a per-port base register, a 32-bit table window with a build-time page size, a 40-bit table window with 64 MB pages, and a 40-bit super-page window with 16 GB pages. The barrier and MSI attribute bits are taken out of the bus address or the table entry, and the translated address, both flags and a fault flag leave the block a fixed two cycles after the request.

Two translation tables are held in synchronous-read register arrays, written through a simple configuration port. The 32-bit table is shared: the super-page window reads its low entries, split in halves between the two ports, and the 32-bit table window indexes the whole table. Software decides which entries it fills. The two direct-map base registers are written through the same port.

Top module: `dma_inbound_xlate`

## Requirements
- R1: A request accepted with `in_valid` high at a rising edge produces `out_valid` high, together with its result, exactly two rising edges later; `out_valid` is low in every other cycle and while `rst` is held.
- R2: An address with bit 63 set translates to a system address of zero in bits 63:54 and bus bits 53:0 below them; the barrier flag is bus bit 62 and the MSI flag is bus bit 61.
- R3: In the 64-bit direct window, any set bit among bus bits 60:54 raises the fault.
- R4: Addresses 0x8000_0000 to 0xFFFF_FFFF translate to the selected port's direct base (bits 63:30) joined with bus bits 29:0; bus bit 30 is the barrier flag and MSI is always low. Both base registers are zero after reset.
- R5: Addresses 0 to 0x7FFF_FFFF use the 32-bit table: bus bit 30 is the barrier flag, the entry index is bus bits 29:0 shifted right by the page shift (default 18, i.e. 256 KB pages), and the MSI flag is entry bit 62.
- R6: Bus bit 30 is stripped before the 32-bit table index is formed, so a barrier and a non-barrier request to the same address give the same system address.
- R7: Addresses 0x40_0000_0000 to 0x7F_FFFF_FFFF use the 40-bit table with index bus bits 37:26; barrier and MSI flags are always low, even when the entry has its MSI bit set.
- R8: Addresses 0x80_0000_0000 to 0xFF_FFFF_FFFF read 32-bit table entry (port × 32 + bus bits 38:34) with 16 GB pages; barrier and MSI flags are always low.
- R9: A table entry holds its valid flag in bit 63, its MSI flag in bit 62 and a page-aligned base in bits 61:0; the result of a table window is the entry base with its in-page bits replaced by the bus address offset, and an entry with bit 63 clear raises the fault.
- R10: An address outside every window, or a table index at or beyond the table depth, raises the fault.
- R11: Whenever the fault flag is high the system address, barrier and MSI outputs are all zero.
- R12: Configuration writes take effect for any request presented after the write edge; `cfg_target` 0 selects the 32-bit table, 1 the 40-bit table and 2 the direct base registers, where `cfg_index` bit 0 picks the port and `cfg_data` bits 63:30 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 64 | Device bus address |
| in_port | input | 1 | Originating port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_target | input | 2 | Configuration target: 0 table32, 1 table40, 2 direct base |
| cfg_index | input | CFG_IDX_W (7) | Entry index or port number |
| cfg_data | input | 64 | Write data |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 64 | Translated system address |
| out_barrier | output | 1 | Barrier attribute |
| out_msi | output | 1 | MSI attribute |
| out_fault | output | 1 | Translation fault |

## Verification
The bench keeps the default 32-bit table of 128 entries with 256 KB pages, so a table-window address with an index of 200 lands beyond the table and exercises the depth fault, while entries 32 to 63 still serve the second port's super pages. It shrinks the 40-bit table to 16 entries, which puts the depth fault of that window within an ordinary address and keeps the table small. With these values every window, both ports' halves of the shared table and the barrier stripping are reached by a handful of hand-computed lookups, issued back to back so the two-stage pipeline carries several requests at once.

// File: rtl/xl_pkg.sv
package xl_pkg;
  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_D64  = 3'd1,
    WIN_D32  = 3'd2,
    WIN_T32  = 3'd3,
    WIN_T40  = 3'd4,
    WIN_SUP  = 3'd5
  } win_e;

  localparam int ADDR_W       = 64;
  localparam int ENT_VALID    = 63;
  localparam int ENT_MSI      = 62;
  localparam int D32_LOW_W    = 30;
  localparam int DBASE_W      = ADDR_W - D32_LOW_W;
  localparam int T40_SHIFT    = 26;
  localparam int SUP_SHIFT    = 34;
  localparam int SUP_PER_PORT = 32;

  localparam logic [1:0] CFG_T32 = 2'd0;
  localparam logic [1:0] CFG_T40 = 2'd1;
  localparam logic [1:0] CFG_DIR = 2'd2;
endpackage

// File: rtl/xl_decode.sv
module xl_decode
  import xl_pkg::*;
#(
  parameter int T32_DEPTH  = 128,
  parameter int T40_DEPTH  = 64,
  parameter int PG32_SHIFT = 18,
  parameter int NPORTS     = 2,
  parameter int T32_IDX_W  = $clog2(T32_DEPTH),
  parameter int T40_IDX_W  = $clog2(T40_DEPTH),
  parameter int PORT_W     = $clog2(NPORTS)
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PORT_W-1:0]    port,
  output win_e                 win,
  output logic [T32_IDX_W-1:0] t32_idx,
  output logic [T40_IDX_W-1:0] t40_idx,
  output logic [ADDR_W-1:0]    eff_addr,
  output logic [ADDR_W-1:0]    off_mask,
  output logic                 barrier,
  output logic                 dmsi,
  output logic                 pre_fault
);
  localparam logic [ADDR_W-1:0] MASK32  = (64'd1 << PG32_SHIFT) - 64'd1;
  localparam logic [ADDR_W-1:0] MASK40  = (64'd1 << T40_SHIFT) - 64'd1;
  localparam logic [ADDR_W-1:0] MASKSUP = (64'd1 << SUP_SHIFT) - 64'd1;

  logic [ADDR_W-1:0] pg;

  always_comb begin
    win       = WIN_NONE;
    eff_addr  = addr;
    off_mask  = '0;
    barrier   = 1'b0;
    dmsi      = 1'b0;
    pre_fault = 1'b0;
    pg        = '0;
    if (addr[63]) begin
      win       = WIN_D64;
      barrier   = addr[62];
      dmsi      = addr[61];
      pre_fault = |addr[60:54];
      eff_addr  = {10'd0, addr[53:0]};
    end else if (addr[62:32] == '0) begin
      barrier  = addr[30];
      eff_addr = {34'd0, addr[29:0]};
      if (addr[31]) begin
        win = WIN_D32;
      end else begin
        win       = WIN_T32;
        off_mask  = MASK32;
        pg        = eff_addr >> PG32_SHIFT;
        pre_fault = (pg >= 64'(T32_DEPTH));
      end
    end else if (addr[62:40] == '0 && addr[39]) begin
      win       = WIN_SUP;
      off_mask  = MASKSUP;
      pg        = 64'(port) * 64'(SUP_PER_PORT) + 64'(addr[38:34]);
      pre_fault = (pg >= 64'(T32_DEPTH));
    end else if (addr[62:39] == '0 && addr[38]) begin
      win       = WIN_T40;
      off_mask  = MASK40;
      pg        = 64'(addr[37:26]);
      pre_fault = (pg >= 64'(T40_DEPTH));
    end else begin
      pre_fault = 1'b1;
    end
  end

  assign t32_idx = pg[T32_IDX_W-1:0];
  assign t40_idx = pg[T40_IDX_W-1:0];
endmodule

// File: rtl/xl_table.sv
module xl_table #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && 32'(widx) < DEPTH) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) begin
      if (32'(ridx) < DEPTH) rdata <= mem[ridx];
      else                   rdata <= '0;
    end
  end
endmodule

// File: rtl/xl_compose.sv
module xl_compose
  import xl_pkg::*;
(
  input  win_e               win,
  input  logic [ADDR_W-1:0]  eff_addr,
  input  logic [ADDR_W-1:0]  off_mask,
  input  logic               barrier,
  input  logic               dmsi,
  input  logic               pre_fault,
  input  logic [ADDR_W-1:0]  ent32,
  input  logic [ADDR_W-1:0]  ent40,
  input  logic [DBASE_W-1:0] dbase,
  output logic [ADDR_W-1:0]  sys_addr,
  output logic               sys_bar,
  output logic               sys_msi,
  output logic               sys_fault
);
  localparam logic [ADDR_W-1:0] BASE_BITS = {2'b00, {(ADDR_W-2){1'b1}}};

  logic [ADDR_W-1:0] ent;
  logic [ADDR_W-1:0] paged;

  assign ent   = (win == WIN_T40) ? ent40 : ent32;
  assign paged = (ent & BASE_BITS & ~off_mask) | (eff_addr & off_mask);

  always_comb begin
    sys_addr  = '0;
    sys_bar   = 1'b0;
    sys_msi   = 1'b0;
    sys_fault = pre_fault;
    unique case (win)
      WIN_D64: begin
        sys_addr = eff_addr;
        sys_bar  = barrier;
        sys_msi  = dmsi;
      end
      WIN_D32: begin
        sys_addr = {dbase, eff_addr[D32_LOW_W-1:0]};
        sys_bar  = barrier;
      end
      WIN_T32: begin
        sys_addr  = paged;
        sys_bar   = barrier;
        sys_msi   = ent[ENT_MSI];
        sys_fault = pre_fault | ~ent[ENT_VALID];
      end
      WIN_T40, WIN_SUP: begin
        sys_addr  = paged;
        sys_fault = pre_fault | ~ent[ENT_VALID];
      end
      default: sys_fault = 1'b1;
    endcase
    if (sys_fault) begin
      sys_addr = '0;
      sys_bar  = 1'b0;
      sys_msi  = 1'b0;
    end
  end
endmodule

// File: rtl/dma_inbound_xlate.sv
module dma_inbound_xlate
  import xl_pkg::*;
#(
  parameter int T32_DEPTH  = 128,
  parameter int T40_DEPTH  = 64,
  parameter int PG32_SHIFT = 18,
  parameter int NPORTS     = 2,
  parameter int T32_IDX_W  = $clog2(T32_DEPTH),
  parameter int T40_IDX_W  = $clog2(T40_DEPTH),
  parameter int PORT_W     = $clog2(NPORTS),
  parameter int CFG_IDX_W  = (T32_IDX_W > T40_IDX_W) ? T32_IDX_W : T40_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic [PORT_W-1:0]    in_port,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_target,
  input  logic [CFG_IDX_W-1:0] cfg_index,
  input  logic [ADDR_W-1:0]    cfg_data,
  output logic                 out_valid,
  output logic [ADDR_W-1:0]    out_addr,
  output logic                 out_barrier,
  output logic                 out_msi,
  output logic                 out_fault
);
  // decode
  win_e                 d_win;
  logic [T32_IDX_W-1:0] d_t32_idx;
  logic [T40_IDX_W-1:0] d_t40_idx;
  logic [ADDR_W-1:0]    d_eff, d_mask;
  logic                 d_bar, d_dmsi, d_pf;

  xl_decode #(
    .T32_DEPTH(T32_DEPTH), .T40_DEPTH(T40_DEPTH), .PG32_SHIFT(PG32_SHIFT),
    .NPORTS(NPORTS), .T32_IDX_W(T32_IDX_W), .T40_IDX_W(T40_IDX_W), .PORT_W(PORT_W)
  ) u_decode (
    .addr(in_addr), .port(in_port), .win(d_win),
    .t32_idx(d_t32_idx), .t40_idx(d_t40_idx),
    .eff_addr(d_eff), .off_mask(d_mask),
    .barrier(d_bar), .dmsi(d_dmsi), .pre_fault(d_pf)
  );

  // translation tables
  logic              we32, we40;
  logic [ADDR_W-1:0] ent32, ent40;

  assign we32 = cfg_we && cfg_target == CFG_T32 && 32'(cfg_index) < T32_DEPTH;
  assign we40 = cfg_we && cfg_target == CFG_T40 && 32'(cfg_index) < T40_DEPTH;

  xl_table #(.DEPTH(T32_DEPTH), .DATA_W(ADDR_W), .IDX_W(T32_IDX_W)) u_t32 (
    .clk(clk), .we(we32), .widx(cfg_index[T32_IDX_W-1:0]), .wdata(cfg_data),
    .re(in_valid), .ridx(d_t32_idx), .rdata(ent32)
  );

  xl_table #(.DEPTH(T40_DEPTH), .DATA_W(ADDR_W), .IDX_W(T40_IDX_W)) u_t40 (
    .clk(clk), .we(we40), .widx(cfg_index[T40_IDX_W-1:0]), .wdata(cfg_data),
    .re(in_valid), .ridx(d_t40_idx), .rdata(ent40)
  );

  // per-port direct-map bases
  logic [DBASE_W-1:0] dbase [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_dbase
    always_ff @(posedge clk) begin
      if (rst) dbase[p] <= '0;
      else if (cfg_we && cfg_target == CFG_DIR && 32'(cfg_index) == p)
        dbase[p] <= cfg_data[ADDR_W-1:D32_LOW_W];
    end
  end

  // stage 1
  logic               s1_valid, s1_bar, s1_dmsi, s1_pf;
  win_e               s1_win;
  logic [ADDR_W-1:0]  s1_eff, s1_mask;
  logic [DBASE_W-1:0] s1_dbase;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_win   <= WIN_NONE;
      s1_eff   <= '0;
      s1_mask  <= '0;
      s1_bar   <= 1'b0;
      s1_dmsi  <= 1'b0;
      s1_pf    <= 1'b0;
      s1_dbase <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_win   <= d_win;
        s1_eff   <= d_eff;
        s1_mask  <= d_mask;
        s1_bar   <= d_bar;
        s1_dmsi  <= d_dmsi;
        s1_pf    <= d_pf;
        s1_dbase <= dbase[in_port];
      end
    end
  end

  // stage 2
  logic [ADDR_W-1:0] c_addr;
  logic              c_bar, c_msi, c_fault;

  xl_compose u_compose (
    .win(s1_win), .eff_addr(s1_eff), .off_mask(s1_mask),
    .barrier(s1_bar), .dmsi(s1_dmsi), .pre_fault(s1_pf),
    .ent32(ent32), .ent40(ent40), .dbase(s1_dbase),
    .sys_addr(c_addr), .sys_bar(c_bar), .sys_msi(c_msi), .sys_fault(c_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_barrier <= 1'b0;
      out_msi     <= 1'b0;
      out_fault   <= 1'b0;
    end else begin
      out_valid   <= s1_valid;
      out_addr    <= c_addr;
      out_barrier <= c_bar;
      out_msi     <= c_msi;
      out_fault   <= c_fault;
    end
  end

  // checks on the pipeline and the per-window output rules
  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  assert_d64_top_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault && $past(s1_win) == WIN_D64) |-> out_addr[63:54] == '0);

  assert_d32_no_msi_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(s1_win) == WIN_D32) |-> !out_msi);

  assert_wide_no_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(s1_win) == WIN_T40 || $past(s1_win) == WIN_SUP))
      |-> (!out_msi && !out_barrier));

  assert_outside_fault_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(s1_win) == WIN_NONE) |-> out_fault);

  assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault) |-> (out_addr == '0 && !out_barrier && !out_msi));
endmodule

// File: tb/tb_dma_inbound_xlate.sv
`timescale 1ns/1ps
module tb_dma_inbound_xlate;
  localparam int T32_DEPTH = 128;
  localparam int T40_DEPTH = 16;
  localparam int IDX_W     = 7;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [63:0]      in_addr = '0;
  logic             in_port = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_target = '0;
  logic [IDX_W-1:0] cfg_index = '0;
  logic [63:0]      cfg_data = '0;
  logic             out_valid, out_barrier, out_msi, out_fault;
  logic [63:0]      out_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_inbound_xlate #(.T32_DEPTH(T32_DEPTH), .T40_DEPTH(T40_DEPTH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_port(in_port),
    .cfg_we(cfg_we), .cfg_target(cfg_target), .cfg_index(cfg_index), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_addr(out_addr), .out_barrier(out_barrier),
    .out_msi(out_msi), .out_fault(out_fault)
  );

  typedef struct {
    logic [63:0] addr;
    logic        bar;
    logic        msi;
    logic        fault;
    string       req;
  } exp_t;

  exp_t sb[$];

  // driver: called at a falling edge, returns at the next one
  task automatic lookup(input logic [63:0] a, input logic p,
                        input logic [63:0] ea, input logic eb, input logic em,
                        input logic ef, input string r);
    exp_t e;
    e.addr = ea; e.bar = eb; e.msi = em; e.fault = ef; e.req = r;
    sb.push_back(e);
    in_valid = 1'b1; in_addr = a; in_port = p;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] t, input int idx, input logic [63:0] d);
    cfg_we = 1'b1; cfg_target = t; cfg_index = IDX_W'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected out_valid: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (out_addr !== e.addr || out_barrier !== e.bar ||
            out_msi !== e.msi || out_fault !== e.fault) begin
          errors++;
          $display("FAIL %s: actual addr=%h bar=%b msi=%b fault=%b expected addr=%h bar=%b msi=%b fault=%b",
                   e.req, out_addr, out_barrier, out_msi, out_fault,
                   e.addr, e.bar, e.msi, e.fault);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_addr !== 64'd0 || out_fault !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: actual valid=%b addr=%h fault=%b expected 0 0 0",
               out_valid, out_addr, out_fault);
    end
    rst = 1'b0;
    @(negedge clk);

    // R4: base of port 1 still zero from reset
    lookup(64'h0000_0000_8000_0044, 1'b1, 64'h44, 1'b0, 1'b0, 1'b0, "R4 reset base");

    // configuration (R12)
    cfg(2'd2, 0, 64'h0000_0012_4000_0000);
    cfg(2'd2, 1, 64'h0000_0100_C000_0000);
    cfg(2'd0, 100, 64'hC000_0055_0004_0000);
    cfg(2'd0, 101, 64'h0000_0066_0000_0000);
    cfg(2'd1, 3,   64'hC000_00AB_0C00_0000);
    cfg(2'd0, 37,  64'hC000_0C00_0000_0000);
    cfg(2'd0, 5,   64'h0000_0000_0000_0000);

    // back-to-back lookups
    lookup(64'h8000_0012_3456_7890, 1'b0, 64'h0000_0012_3456_7890, 1'b0, 1'b0, 1'b0, "R2 d64 plain");
    lookup(64'hE000_0000_0000_1000, 1'b0, 64'h1000, 1'b1, 1'b1, 1'b0, "R2 d64 barrier msi");
    lookup(64'h8040_0000_0000_0000, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1, "R3 d64 reserved bit");
    lookup(64'h0000_0000_8123_4567, 1'b0, 64'h0000_0012_4123_4567, 1'b0, 1'b0, 1'b0, "R4 d32 port0");
    lookup(64'h0000_0000_C000_0010, 1'b1, 64'h0000_0100_C000_0010, 1'b1, 1'b0, 1'b0, "R4 d32 port1 barrier");
    lookup(64'h0000_0000_0190_1234, 1'b0, 64'h0000_0055_0004_1234, 1'b0, 1'b1, 1'b0, "R5 t32 hit");
    lookup(64'h0000_0000_4190_1234, 1'b0, 64'h0000_0055_0004_1234, 1'b1, 1'b1, 1'b0, "R6 t32 barrier same entry");
    lookup(64'h0000_0000_0194_0000, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1, "R9 t32 invalid entry");
    lookup(64'h0000_0000_0320_0000, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1, "R10 t32 index beyond depth");
    lookup(64'h0000_0040_0C12_3456, 1'b0, 64'h0000_00AB_0C12_3456, 1'b0, 1'b0, 1'b0, "R7 t40 hit msi dropped");
    lookup(64'h0000_0040_5000_0000, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1, "R10 t40 index beyond depth");
    lookup(64'h0000_0095_2345_6789, 1'b1, 64'h0000_0C01_2345_6789, 1'b0, 1'b0, 1'b0, "R8 super port1");
    lookup(64'h0000_0095_2345_6789, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1, "R8 super port0 other half");
    lookup(64'h0000_0001_0000_0000, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1, "R10 gap below 40-bit table");
    lookup(64'h0000_0100_0000_0000, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1, "R10 above super window");
    lookup(64'h4000_0000_0000_0000, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1, "R11 bit62 only fault quiet");

    // R12: rewrite an entry and look again
    cfg(2'd0, 100, 64'h8000_0077_0000_0000);
    lookup(64'h0000_0000_0190_1234, 1'b0, 64'h0000_0077_0000_1234, 1'b0, 1'b0, 1'b0, "R12 rewritten entry");

    repeat (5) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 results missing: actual %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog expired: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule